// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral with a small register window. Software loads a start value into a countdown counter by writing the kick register. The counter then steps down once per tick while the halt bit is clear. A tick is produced by an internal prescaler that divides the system clock by `TICK_DIV`. When the counter would pass from 1 to 0, the block records an expiry and the counter reloads itself from the start-value register.

The first expiry sets a timeout flag. Software is expected to clear that flag by writing a one to it. If another expiry happens while the flag is still set, the block treats it as a second timeout. It latches two further status bits and issues a one-cycle system-action pulse, but only if the no-reboot strap input is low. The upstream logic decides what that pulse does.

The window also provides:
- two mailbox bytes, where a write to either byte sets a matching software-interrupt status bit;
- a sticky lock bit;
- three plain storage registers.

Reads are combinational. Writes carry per-byte enables and take effect on the clock edge.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the registers read as follows, by word address: kick/count (0) 0x0000, mailbox (1) 0x0000, status A (2) 0x0000, status B (3) 0x0000, control A (4) 0x0000, control B (5) 0x0008, message (6) 0x0000, start value (7) 0x0004, soft-IRQ (8) 0x0003.
- R2: Any write to address 0 copies the start-value register into the counter, and address 0 then reads that value.
- R3: While running, the counter drops by one every `TICK_DIV` clock cycles. The tick phase restarts at each kick and holds while halted.
- R4: After a kick to N, the counter reads 1 with status A bit 3 (timeout) still clear after N-1 ticks. On tick N, bit 3 becomes set and the counter reloads to N.
- R5: Control A bit 11 (halt) set freezes the counter and the tick phase. Clearing it resumes counting.
- R6: An expiry while status A bit 3 is already set sets status B bit 1 (second timeout) and bit 2 (boot), so status B reads 0x0006.
- R7: A second timeout drives `sys_action` high for exactly one cycle when `no_reboot` is low. No pulse is produced when `no_reboot` is high.
- R8: Status bits clear when a one is written to their position. Writing back the value just read clears the register to 0.
- R9: Control A bit 12 (lock) stays 1 once written to 1, whatever is written later. Only reset clears it.
- R10: A write to the mailbox low byte (in) sets status A bit 0, and a write to the high byte (out) sets status A bit 1. Each written byte is stored and read back.
- R11: The start-value register keeps only its low `CNT_W` bits, so writing 0xFFFF reads back 0x03FF with `CNT_W` = 10.
- R12: A counter holding 0 neither counts nor expires, even while running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word address of the register window |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| no_reboot | input | 1 | Strap that suppresses the system action |
| sys_action | output | 1 | One-cycle pulse on an ungated second timeout |

## Verification
The bound checker watches several rules on every cycle:
- lock stickiness;
- the single-cycle, strap-gated shape of the action pulse;
- the counter staying still while halted;
- the decrement-by-one and reload-on-expiry steps on a tick;
- the second-timeout bits following an expiry that meets a set flag.

Some behaviour depends on register values and scripted sequences, so only the bench scenarios can show it:
- the reset values;
- the exact tick count at which the timeout flag appears;
- write-one-to-clear through write-back;
- the mailbox side effects;
- start-value masking;
- the idle behaviour of a zero counter.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [3:0] {
        A_KICK  = 4'd0,
        A_MBOX  = 4'd1,
        A_STATA = 4'd2,
        A_STATB = 4'd3,
        A_CTLA  = 4'd4,
        A_CTLB  = 4'd5,
        A_MSG   = 4'd6,
        A_START = 4'd7,
        A_SWIRQ = 4'd8
    } wdt_addr_e;

    // status A bit positions
    localparam int SA_MB_IN   = 0;
    localparam int SA_MB_OUT  = 1;
    localparam int SA_TIMEOUT = 3;
    // status B bit positions
    localparam int SB_SECOND  = 1;
    localparam int SB_BOOT    = 2;
    // control A bit positions
    localparam int CA_HALT    = 11;
    localparam int CA_LOCK    = 12;

    localparam logic [15:0] RST_CTLB  = 16'h0008;
    localparam logic [15:0] RST_START = 16'h0004;
    localparam logic [7:0]  RST_SWIRQ = 8'h03;

    typedef struct packed {
        logic timeout;
        logic mb_out;
        logic mb_in;
    } stat_a_t;

    typedef struct packed {
        logic boot;
        logic second;
    } stat_b_t;

    typedef struct packed {
        logic lock;
        logic halt;
    } ctl_a_t;

    // byte-enable merge of new write data over an old register value
    function automatic logic [15:0] be_merge(input logic [15:0] old_v,
                                             input logic [15:0] new_v,
                                             input logic [1:0]  be);
        logic [15:0] r;
        r[7:0]  = be[0] ? new_v[7:0]  : old_v[7:0];
        r[15:8] = be[1] ? new_v[15:8] : old_v[15:8];
        return r;
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            logic unused_ok;
            assign unused_ok = clk ^ rst ^ restart;
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(TICK_DIV);
            localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
            logic [PW-1:0] phase;
            logic          wrap;

            assign wrap = (phase == LAST);

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    phase <= '0;
                end else if (run) begin
                    phase <= wrap ? '0 : phase + 1'b1;
                end
            end

            assign tick = run & wrap;
        end
    endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick & ~load & (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start_val;
        end else if (tick && cnt != '0) begin
            cnt <= (cnt == ONE) ? start_val : cnt - ONE;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       addr,
    input  logic             wr,
    input  logic [1:0]       be,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata,
    input  logic             no_reboot,
    input  logic [CNT_W-1:0] cnt,
    input  logic             expire,
    output logic             load,
    output logic             running,
    output logic [CNT_W-1:0] start_val,
    output logic             action,
    output logic             first_flag,
    output logic             second_flag,
    output logic             lock_flag
);
    stat_a_t     sa;
    stat_b_t     sb;
    ctl_a_t      ca;
    logic [7:0]  mb_in, mb_out, swirq;
    logic [15:0] ctlb, msg;
    logic        act_q;

    logic [15:0] ca_word, st_word;
    logic        w_kick, w_mbox, w_sa, w_sb, w_ca, w_cb, w_msg, w_st, w_sw;
    logic        second_evt;

    assign w_kick = wr && (addr == A_KICK);
    assign w_mbox = wr && (addr == A_MBOX);
    assign w_sa   = wr && (addr == A_STATA);
    assign w_sb   = wr && (addr == A_STATB);
    assign w_ca   = wr && (addr == A_CTLA);
    assign w_cb   = wr && (addr == A_CTLB);
    assign w_msg  = wr && (addr == A_MSG);
    assign w_st   = wr && (addr == A_START);
    assign w_sw   = wr && (addr == A_SWIRQ);

    always_comb begin
        ca_word = '0;
        ca_word[CA_HALT] = ca.halt;
        ca_word[CA_LOCK] = ca.lock;
    end

    assign st_word    = be_merge(16'(start_val), wdata, be);
    assign second_evt = expire & sa.timeout;

    // control, storage and mailbox registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ca        <= '0;
            ctlb      <= RST_CTLB;
            msg       <= '0;
            start_val <= CNT_W'(RST_START);
            swirq     <= RST_SWIRQ;
            mb_in     <= '0;
            mb_out    <= '0;
        end else begin
            if (w_ca) begin
                ca.halt <= be_merge(ca_word, wdata, be)[CA_HALT];
                ca.lock <= ca.lock | be_merge(ca_word, wdata, be)[CA_LOCK];
            end
            if (w_cb)  ctlb      <= be_merge(ctlb, wdata, be);
            if (w_msg) msg       <= be_merge(msg, wdata, be);
            if (w_st)  start_val <= st_word[CNT_W-1:0];
            if (w_sw && be[0]) swirq <= wdata[7:0];
            if (w_mbox && be[0]) mb_in  <= wdata[7:0];
            if (w_mbox && be[1]) mb_out <= wdata[15:8];
        end
    end

    // status registers: set events win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            sa    <= '0;
            sb    <= '0;
            act_q <= 1'b0;
        end else begin
            sa.timeout <= (sa.timeout & ~(w_sa & be[0] & wdata[SA_TIMEOUT])) | expire;
            sa.mb_in   <= (sa.mb_in   & ~(w_sa & be[0] & wdata[SA_MB_IN]))   | (w_mbox & be[0]);
            sa.mb_out  <= (sa.mb_out  & ~(w_sa & be[0] & wdata[SA_MB_OUT]))  | (w_mbox & be[1]);
            sb.second  <= (sb.second  & ~(w_sb & be[0] & wdata[SB_SECOND]))  | second_evt;
            sb.boot    <= (sb.boot    & ~(w_sb & be[0] & wdata[SB_BOOT]))    | second_evt;
            act_q      <= second_evt & ~no_reboot;
        end
    end

    always_comb begin
        rdata = '0;
        case (wdt_addr_e'(addr))
            A_KICK:  rdata = 16'(cnt);
            A_MBOX:  rdata = {mb_out, mb_in};
            A_STATA: begin
                rdata[SA_TIMEOUT] = sa.timeout;
                rdata[SA_MB_OUT]  = sa.mb_out;
                rdata[SA_MB_IN]   = sa.mb_in;
            end
            A_STATB: begin
                rdata[SB_SECOND] = sb.second;
                rdata[SB_BOOT]   = sb.boot;
            end
            A_CTLA:  rdata = ca_word;
            A_CTLB:  rdata = ctlb;
            A_MSG:   rdata = msg;
            A_START: rdata = 16'(start_val);
            A_SWIRQ: rdata = {8'h00, swirq};
            default: rdata = '0;
        endcase
    end

    assign load        = w_kick;
    assign running     = ~ca.halt;
    assign action      = act_q;
    assign first_flag  = sa.timeout;
    assign second_flag = sb.second;
    assign lock_flag   = ca.lock;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int TICK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [1:0]  reg_be,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        no_reboot,
    output logic        sys_action
);
    logic             tick, load, running, expire;
    logic             first_flag, second_flag, lock_flag;
    logic [CNT_W-1:0] cnt, start_val;

    wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .run(running), .restart(load), .tick(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load(load),
        .start_val(start_val), .cnt(cnt), .expire(expire)
    );

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .be(reg_be),
        .wdata(reg_wdata), .rdata(reg_rdata), .no_reboot(no_reboot),
        .cnt(cnt), .expire(expire), .load(load), .running(running),
        .start_val(start_val), .action(sys_action), .first_flag(first_flag),
        .second_flag(second_flag), .lock_flag(lock_flag)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             load,
    input logic             running,
    input logic             expire,
    input logic             first_flag,
    input logic             second_flag,
    input logic             lock_flag,
    input logic             no_reboot,
    input logic             sys_action,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] start_val
);
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        lock_flag |=> lock_flag);

    p_action_gated_r7: assert property (@(posedge clk) disable iff (rst)
        sys_action |-> !$past(no_reboot));

    p_action_single_r7: assert property (@(posedge clk) disable iff (rst)
        sys_action |=> !sys_action);

    p_halt_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!running && !load) |=> $stable(cnt));

    p_tick_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
        tick |-> running);

    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_expiry_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt == CNT_W'(1)) |=> (cnt == $past(start_val) && first_flag));

    p_second_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && first_flag) |=> second_flag);

    p_zero_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && !load) |=> (cnt == '0));
endmodule

bind wdt_two_stage wdt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .load(load), .running(running),
    .expire(expire), .first_flag(first_flag), .second_flag(second_flag),
    .lock_flag(lock_flag), .no_reboot(no_reboot), .sys_action(sys_action),
    .cnt(cnt), .start_val(start_val)
);

// File: tb/sim_wdt_two_stage.sv
module sim_wdt_two_stage;
    localparam int CNT_W = 10;
    localparam int DIV   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        no_reboot = 1'b0;
    logic        sys_action;

    wdt_two_stage #(.CNT_W(CNT_W), .TICK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .no_reboot(no_reboot), .sys_action(sys_action)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [15:0] exp;
        bit          use_pulses;
        string       tag;
    } item_t;

    item_t q[$];
    event  smp;
    int    n_cmp = 0;
    int    n_bad = 0;
    int    pulses = 0;
    bit    done = 0;

    always @(negedge clk) if (!rst && sys_action) pulses++;

    // monitor: compares each queued expectation against the observed value
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] obs;
                it  = q.pop_front();
                obs = it.use_pulses ? 16'(pulses) : reg_rdata;
                n_cmp++;
                if (obs !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got 0x%04h expected 0x%04h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic chk_rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        item_t it;
        reg_addr = a;
        #1;
        it.exp = e; it.use_pulses = 0; it.tag = tag;
        q.push_back(it);
        -> smp;
        #1;
    endtask

    task automatic chk_pulses(input int e, input string tag);
        item_t it;
        it.exp = 16'(e); it.use_pulses = 1; it.tag = tag;
        q.push_back(it);
        -> smp;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_be = be; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic ticks(input int k);
        repeat (k * DIV) @(posedge clk);
        @(negedge clk);
    endtask

    logic [15:0] tmp;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 defaults
        chk_rd(4'd0, 16'h0000, "R1 count");
        chk_rd(4'd1, 16'h0000, "R1 mailbox");
        chk_rd(4'd2, 16'h0000, "R1 statA");
        chk_rd(4'd3, 16'h0000, "R1 statB");
        chk_rd(4'd4, 16'h0000, "R1 ctlA");
        chk_rd(4'd5, 16'h0008, "R1 ctlB");
        chk_rd(4'd6, 16'h0000, "R1 msg");
        chk_rd(4'd7, 16'h0004, "R1 start");
        chk_rd(4'd8, 16'h0003, "R1 swirq");

        // R12 zero counter stays idle while running
        ticks(3);
        chk_rd(4'd0, 16'h0000, "R12 idle count");
        chk_rd(4'd2, 16'h0000, "R12 no expiry");

        // R2 / R5 halted load
        wr(4'd4, 2'b10, 16'h0800);
        wr(4'd7, 2'b11, 16'd5);
        wr(4'd0, 2'b11, 16'h0000);
        chk_rd(4'd0, 16'd5, "R2 kick loads start value");
        ticks(3);
        chk_rd(4'd0, 16'd5, "R5 halted counter frozen");

        // R3 / R4 run
        wr(4'd4, 2'b10, 16'h0000);
        chk_rd(4'd0, 16'd5, "R5 resume value");
        ticks(1);
        chk_rd(4'd0, 16'd4, "R3 one tick");
        ticks(3);
        chk_rd(4'd0, 16'd1, "R4 N-1 ticks count");
        chk_rd(4'd2, 16'h0000, "R4 no timeout yet");
        ticks(1);
        chk_rd(4'd2, 16'h0008, "R4 timeout on tick N");
        chk_rd(4'd0, 16'd5, "R4 reload on expiry");
        chk_rd(4'd3, 16'h0000, "R6 first expiry no second");

        // R8 clear timeout
        wr(4'd4, 2'b10, 16'h0800);
        wr(4'd2, 2'b01, 16'h0008);
        chk_rd(4'd2, 16'h0000, "R8 timeout cleared");

        // first again, then second
        wr(4'd0, 2'b11, 16'h0000);
        wr(4'd4, 2'b10, 16'h0000);
        ticks(5);
        chk_rd(4'd2, 16'h0008, "R4 fresh first expiry");
        chk_rd(4'd3, 16'h0000, "R6 no second after clear");
        chk_pulses(0, "R7 no pulse on first");
        ticks(5);
        chk_rd(4'd3, 16'h0006, "R6 second timeout bits");
        chk_pulses(1, "R7 one action pulse");

        // R8 write-back clears
        wr(4'd4, 2'b10, 16'h0800);
        reg_addr = 4'd3; #1; tmp = reg_rdata;
        wr(4'd3, 2'b11, tmp);
        chk_rd(4'd3, 16'h0000, "R8 write-back clears statB");

        // R7 gated by no_reboot
        no_reboot = 1'b1;
        wr(4'd0, 2'b11, 16'h0000);
        wr(4'd4, 2'b10, 16'h0000);
        ticks(5);
        chk_rd(4'd3, 16'h0006, "R6 second with no_reboot");
        chk_pulses(1, "R7 no pulse when no_reboot");
        wr(4'd4, 2'b10, 16'h0800);

        // R9 lock sticky
        wr(4'd4, 2'b10, 16'h1800);
        chk_rd(4'd4, 16'h1800, "R9 lock set");
        wr(4'd4, 2'b11, 16'h0800);
        chk_rd(4'd4, 16'h1800, "R9 lock survives clear write");

        // R10 mailbox
        wr(4'd2, 2'b01, 16'h0008);
        wr(4'd1, 2'b01, 16'h005A);
        chk_rd(4'd2, 16'h0001, "R10 data-in sets bit0");
        wr(4'd1, 2'b10, 16'hA500);
        chk_rd(4'd2, 16'h0003, "R10 data-out sets bit1");
        chk_rd(4'd1, 16'hA55A, "R10 mailbox bytes");
        wr(4'd2, 2'b11, 16'h0003);
        chk_rd(4'd2, 16'h0000, "R8 statA write-back");

        // R11 masking
        wr(4'd7, 2'b11, 16'hFFFF);
        chk_rd(4'd7, 16'h03FF, "R11 start masked");

        // R9 reset clears lock
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk_rd(4'd4, 16'h0000, "R9 reset clears lock");
        chk_rd(4'd7, 16'h0004, "R1 start after reset");

        #5;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule